// File: doc/BRIEF.md
# Programmable Clock Post-Divider with Gating

This block takes a reference clock and produces a slower output clock. The output period is a whole number of reference cycles, set by a 5-bit divide factor. Software reaches the block through one 32-bit register that has a plain write strobe and combinational readback. The register holds the divide factor and a gating mode. It also reports whether the output is running, and carries a toggle bit that confirms a new setting has reached the output.

A new setting never cuts into an output period that is already under way. It waits until the current period ends, and then the counter, the gate state and the acknowledge bit all change together. In automatic mode the output runs only while a downstream consumer raises its request input. In forced mode the output runs all the time. A divide factor of 1 passes the reference clock through while the output is enabled.

Top module: `postdiv_gate`

## Requirements
- R1: After reset the register reads 0x00000001 and the output is low. The divide field is 1, and the acknowledge, gate-mode and status bits are all 0.
- R2: The register layout is as follows. Bits 4:0 are the divide field (read/write). Bit 5 is the acknowledge bit (read-only). Bit 8 is the gate mode (read/write, 1 = forced on). Bit 9 is the status bit (read-only). Bits 31:10 and 7:6 always read 0, whatever was written to them.
- R3: Let N be the effective factor, which is 1 when the field holds 0 and the field value otherwise. For N of 2 or more, each output period lasts N reference cycles: it is high for floor(N/2) cycles at the start and low for the rest. For N = 1, the enabled output equals the reference clock.
- R4: A write takes effect only at the last cycle of the current output period. On that same clock edge bit 5 inverts and a new period begins with its full high phase, so no shortened pulse appears.
- R5: Every register write arms exactly one reload. Several writes before one period end produce a single toggle of bit 5. Writing back the value already in use still produces exactly one toggle.
- R6: When bit 8 is 0, the output is enabled only while the request input is high. When bit 8 is 1, it stays enabled whatever the request input does. The enable state changes only at a period end, and a disabled output is held low.
- R7: Bit 9 reads 1 while the output is enabled and changes on the same edge as the enable state. For N of 2 or more, a newly enabled output is high on that edge. For N = 1 it follows the reference clock from the next cycle onward.
- R8: A stored divide field of 0 reads back as 0 and divides by 1.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock from the PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| clk_req | input | 1 | Downstream clock request |
| rd_data | output | 32 | Register readback |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
The hardest case to reach is a write landing just as a long period ends, or two writes falling inside one period. The first tests whether a reload can split a pulse; the second tests whether the acknowledge bit toggles once or twice. The stimulus first sets a factor of 31 and lines up on the acknowledge edge, which leaves nearly thirty quiet cycles. It then places back-to-back writes in that window. Random factors are also written after random delays, so the write lands at an arbitrary point in the period. Each time, the output waveform is compared sample by sample from the acknowledge edge onward.

// File: rtl/postdiv_gate.sv
`timescale 1ns/1ps
module postdiv_gate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        clk_req,
  output logic [31:0] rd_data,
  output logic        clk_out
);
  localparam int DW = 5;

  logic [DW-1:0] div_q, cur_n, cnt;
  logic gate_force_q, ack_q, pend_q, run_q, ph_q, byp_l, en_l;

  wire last = (cnt == cur_n - 5'd1);
  wire [DW-1:0] eff_n = (div_q == '0) ? 5'd1 : div_q;
  wire want_run = gate_force_q | clk_req;
  wire unused_wr = ^{wr_data[31:9], wr_data[7:5]};

  logic [DW-1:0] cnt_nx, n_nx;
  always_comb begin
    cnt_nx = last ? '0 : cnt + 5'd1;
    n_nx   = (last && pend_q) ? eff_n : cur_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q        <= 5'd1;
      gate_force_q <= 1'b0;
      pend_q       <= 1'b0;
    end else if (wr_en) begin
      div_q        <= wr_data[DW-1:0];
      gate_force_q <= wr_data[8];
      pend_q       <= 1'b1;
    end else if (last) begin
      pend_q       <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_n <= 5'd1;
      cnt   <= '0;
      ack_q <= 1'b0;
      run_q <= 1'b0;
      ph_q  <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      cur_n <= n_nx;
      ph_q  <= cnt_nx < (n_nx >> 1);
      if (last) run_q <= want_run;
      if (last && pend_q) ack_q <= ~ack_q;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_l <= 1'b1;
      en_l  <= 1'b0;
    end else begin
      byp_l <= (cur_n == 5'd1);
      en_l  <= run_q;
    end
  end

  assign clk_out = (byp_l & en_l & clk) | (ph_q & run_q);
  assign rd_data = {22'd0, run_q, gate_force_q, 2'd0, ack_q, div_q};
endmodule

module postdiv_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] cnt,
  input logic [4:0] cur_n,
  input logic       pend,
  input logic       ack,
  input logic       run,
  input logic       ph,
  input logic       force_on
);
  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < cur_n);
  p_high_starts_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph) |-> cnt == 5'd0);
  p_ack_at_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack) |-> $past(pend && cnt == cur_n - 5'd1));
  p_ack_once_per_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && cnt == cur_n - 5'd1) |=> ack != $past(ack));
  p_run_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run) |-> $past(cnt == cur_n - 5'd1));
  p_forced_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_on && cnt == cur_n - 5'd1) |=> run);
endmodule

bind postdiv_gate postdiv_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .cur_n(cur_n), .pend(pend_q),
  .ack(ack_q), .run(run_q), .ph(ph_q), .force_on(gate_force_q)
);

// File: tb/sim_postdiv_gate.sv
`timescale 1ns/1ps
module sim_postdiv_gate;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, clk_req = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic clk_out;
  int checks = 0, fails = 0, old_n = 1;

  postdiv_gate u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                   .clk_req(clk_req), .rd_data(rd_data), .clk_out(clk_out));

  always #5 clk = ~clk;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction
  function automatic int exp_out(input int n, input int i);
    return ((i % n) < (n / 2)) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_ack(input bit a0, input int lim, output bit found);
    found = 1'b0;
    for (int k = 0; k < lim; k++) begin
      step();
      if (rd_data[5] != a0) begin found = 1'b1; break; end
    end
  endtask

  task automatic pattern(input int n, input string req);
    bit a = rd_data[5];
    int extra = 0;
    if (n == 1) begin
      step();
      for (int i = 0; i < 4; i++) begin
        chk(req, int'(clk_out), 1);
        if (rd_data[5] != a) extra++;
        step();
      end
    end else begin
      for (int i = 0; i < 2 * n; i++) begin
        chk(req, int'(clk_out), exp_out(n, i));
        if (rd_data[5] != a) extra++;
        step();
      end
    end
    chk("R5 single toggle", extra, 0);
  endtask

  task automatic apply(input logic [31:0] v);
    bit a0, found;
    a0 = rd_data[5];
    wr(v);
    wait_ack(a0, old_n + 3, found);
    chk("R4 ack toggles at period end", int'(found), 1);
    chk("R8 divide field readback", int'(rd_data[4:0]), int'(v[4:0]));
    chk("R7 status enabled", int'(rd_data[9]), 1);
    pattern(eff(int'(v[4:0])), "R3 output waveform");
    old_n = eff(int'(v[4:0]));
  endtask

  task automatic wait_status(input bit want, output bit found);
    found = 1'b0;
    for (int k = 0; k < 40; k++) begin
      step();
      if (rd_data[9] == want) begin found = 1'b1; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit found, a0;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step();
    chk("R1 reset readback", int'(rd_data), 32'h1);
    chk("R1 reset output low", int'(clk_out), 0);

    // R2: reserved bits and field placement
    apply(32'hFFFF_FFFF);
    chk("R2 reserved bits zero", int'(rd_data & 32'hFFFF_FCC0), 0);
    chk("R2 gate mode bit", int'(rd_data[8]), 1);

    // R3: every factor
    for (int n = 1; n <= 31; n++) apply(32'h100 | n);
    // R8: zero means divide by one
    apply(32'h100);
    apply(32'h106);

    // R5: rewrite the same value
    apply(32'h106);

    // R5: two writes inside one long period
    apply(32'h11F);
    a0 = rd_data[5];
    wr(32'h103);
    wr(32'h107);
    wait_ack(a0, 40, found);
    chk("R5 coalesced ack", int'(found), 1);
    chk("R5 last write wins", int'(rd_data[4:0]), 7);
    pattern(7, "R4 no runt after coalesced change");
    old_n = 7;

    // random factors, random write phase
    for (int r = 0; r < 40; r++) begin
      int v = int'($urandom_range(31, 0));
      repeat (int'($urandom_range(10, 0))) step();
      apply(32'h100 | v);
    end

    // R6/R7: auto gating, N = 4
    apply(32'h104);
    clk_req = 1'b0;
    wr(32'h004);
    wait_status(1'b0, found);
    chk("R6 auto gate off", int'(found), 1);
    for (int i = 0; i < 12; i++) begin
      chk("R6 gated output low", int'(clk_out), 0);
      chk("R7 status gated", int'(rd_data[9]), 0);
      step();
    end
    @(negedge clk); clk_req = 1'b1;
    wait_status(1'b1, found);
    chk("R7 status on request", int'(found), 1);
    pattern(4, "R7 ungated full high phase");
    @(negedge clk); clk_req = 1'b0;
    wait_status(1'b0, found);
    chk("R6 request drop gates", int'(found), 1);
    // R6: forced mode ignores request
    wr(32'h104);
    wait_status(1'b1, found);
    chk("R6 force enables", int'(found), 1);
    for (int i = 0; i < 20; i++) begin
      chk("R6 forced status held", int'(rd_data[9]), 1);
      step();
    end

    // R7: bypass gating lags one cycle
    old_n = 4;
    apply(32'h101);
    wr(32'h001);
    wait_status(1'b0, found);
    chk("R6 bypass gate off", int'(found), 1);
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R7 bypass gated low", int'(clk_out), 0);
    end
    @(negedge clk); clk_req = 1'b1;
    wait_status(1'b1, found);
    chk("R7 bypass status on", int'(found), 1);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R7 bypass follows clock", int'(clk_out), 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule